// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of a programmable interval timer. It holds a 16-bit down counter that advances on a count strobe, a gate input that enables, suspends or triggers counting depending on the mode, and one output pin whose waveform is set by the programmed mode. Software programs the channel through an 8-bit register port: a control word picks the mode, the byte access order and binary or decimal counting, and later data writes load the initial count.

Six counting behaviours are available: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square wave, and two single-pulse strobes, one started by a count write and one by a gate edge. The count can be read live, frozen with a latch command without stopping the counter, or captured together with a status byte through a read-back command. The channel number is a parameter, so several copies can share one control bus. Each copy acts only on control words that carry its own number.

All timing is synchronous to `clk`. `cntTick` is a one-cycle enable that marks one count clock period. The gate rising edge is found by comparing `gate` with its value in the previous `clk` cycle.

Top module: `pit_channel`

## Requirements
- R1: A control word (wrCtl=1) has channel bits [7:6], access bits [5:4] (00 latch, 01 low byte only, 10 high byte only, 11 low then high), mode bits [3:1] (codes 6 and 7 act as 2 and 3) and a decimal flag in bit 0. Writing one sets outPin low for mode 0 and high for every other mode, one clock later. After reset outPin is low and rdData is 0.
- R2: With low-only access a data write sets the count to {0, byte}. With high-only access it sets the count to {byte, 0}, and reads return the low or the high byte of the count. With low-then-high access, writes and reads alternate between the low byte and the high byte, starting with the low byte.
- R3: Mode 0: outPin goes low when the count is written. The first tick loads the count, and outPin goes high on tick N+1 and stays high until the next write. While gate is low the count does not change.
- R4: Mode 1: a gate rising edge arms a trigger. The next tick loads the count and drives outPin low, and outPin returns high N ticks later. A new rising edge restarts the low period from the full count.
- R5: Mode 2: after the load, outPin is low for one tick out of every N ticks, on tick k when k mod N = 0. A low gate forces outPin high and stops counting. A gate rising edge reloads the count on the next tick.
- R6: Mode 3: outPin is high for ceil(N/2) ticks and low for floor(N/2) ticks of each N-tick period, and this holds in decimal counting too.
- R7: Mode 4: the first tick after a count write loads the count. On tick N+1 outPin is low for exactly one tick, once per count write.
- R8: Mode 5: same as mode 4, but the load is started by a gate rising edge, and a new edge restarts the count.
- R9: In decimal mode the counter counts down in packed decimal digits (0x0010 goes to 0x0009, 0x0000 goes to 0x9999). In binary mode 0x0000 goes to 0xFFFF.
- R10: A latch command (access bits 00) freezes the current count for reading while counting continues. Further latch commands are ignored until the frozen value has been fully read.
- R11: A read-back command (channel bits 11) latches the count when bit 5 is set and the status when bit 4 is set, for each channel whose bit [1+channel] is set. The status byte is {outPin, nullCount, access[1:0], mode[2:0], decimal}. A latched status is read before the count.
- R12: The null-count status flag is set by a control word or by a completed count write, and it is cleared when the count is loaded into the counter.
- R13: Control words that carry another channel number leave the channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | One-cycle count clock enable |
| gate | input | 1 | Gate input (enable or trigger, depending on mode) |
| wrEn | input | 1 | Register write strobe |
| wrCtl | input | 1 | 1: control word, 0: count data |
| wrData | input | 8 | Write data byte |
| rdEn | input | 1 | Read strobe; advances the byte sequence |
| rdData | output | 8 | Read data (status, latched or live count byte) |
| outPin | output | 1 | Channel output |

## Verification
The bench sweeps the count for the rate and square-wave modes and compares outPin after every tick with a value computed from the tick index. A wrong reload point would shift the low pulse by one tick, and a wrong halving would swap the high and low lengths for odd counts. An odd decimal count checks that the halving works per digit and not as a binary shift. The one-shot and the hardware strobe are retriggered partway through, so a design that ignores the second edge would release its output too early. The latch and read-back checks issue a second latch and count on past it, so a design that re-latched, or that stopped the counter while a value was held, would return the wrong bytes. The status byte is checked to come out ahead of the count bytes.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam logic [2:0] MODE_TERM  = 3'd0;
  localparam logic [2:0] MODE_ONESH = 3'd1;
  localparam logic [2:0] MODE_RATE  = 3'd2;
  localparam logic [2:0] MODE_SQR   = 3'd3;
  localparam logic [2:0] MODE_SWSTB = 3'd4;
  localparam logic [2:0] MODE_HWSTB = 3'd5;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LO    = 2'b01;
  localparam logic [1:0] ACC_HI    = 2'b10;
  localparam logic [1:0] ACC_BOTH  = 2'b11;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic load;
    logic dec;
  } ceCtlT;

endpackage

// File: rtl/pit_count_path.sv
module pit_count_path
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ceCtlT            ctl,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             bcdSel,
  output logic [CNT_W-1:0] ceVal,
  output logic [CNT_W-1:0] ceDec,
  output logic [CNT_W-1:0] halfVal
);
  localparam int DIGITS = CNT_W / 4;

  function automatic logic [CNT_W-1:0] decDigits(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] halfDigits(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic odd;
    r = '0;
    odd = 1'b0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      r[4*i +: 4] = {1'b0, v[4*i+1 +: 3]} + (odd ? 4'd5 : 4'd0);
      odd = v[4*i];
    end
    return r;
  endfunction

  logic [CNT_W-1:0] ceQ;

  always_ff @(posedge clk) begin
    if (!rstN)        ceQ <= '0;
    else if (ctl.load) ceQ <= reloadVal;
    else if (ctl.dec)  ceQ <= ceDec;
  end

  always_comb begin
    ceDec = bcdSel ? decDigits(ceQ) : ceQ - CNT_W'(1);
    // a zero count means the full range of the counter
    if (reloadVal == '0)
      halfVal = bcdSel ? (CNT_W'(5) << (CNT_W - 4)) : {1'b1, {(CNT_W-1){1'b0}}};
    else
      halfVal = bcdSel ? halfDigits(reloadVal) : (reloadVal >> 1);
  end

  assign ceVal = ceQ;

endmodule

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = 8,
  localparam int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic              gate,
  input  logic              wrEn,
  input  logic              wrCtl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  ceVal,
  input  logic [CNT_W-1:0]  ceDec,
  input  logic [CNT_W-1:0]  halfVal,
  output ceCtlT             ctl,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [2:0]        modeSel,
  output logic              bcdSel,
  output logic              outPin,
  output logic [BYTE_W-1:0] rdData
);
  logic [1:0]        acc;
  logic              outQ, nullCnt, loadPend, armed, running, pulseArm, crValid;
  logic              wrHi, rdHi, latchValid, statusValid, gatePrev;
  logic [CNT_W-1:0]  latchVal, srcVal;
  logic [BYTE_W-1:0] statusVal;
  logic [2:0]        newMode;
  logic              ctlHit, mine, isCtlWord, isLatchCmd, rbMe, dataWr, countDone;
  logic              gateRise, hwMode, periodic, countOn, doLoad, termReload, byteHi;

  always_comb begin
    ctlHit     = wrEn & wrCtl;
    mine       = wrData[7:6] == 2'(CHAN_ID);
    isCtlWord  = ctlHit & mine & (wrData[5:4] != ACC_LATCH);
    isLatchCmd = ctlHit & mine & (wrData[5:4] == ACC_LATCH);
    rbMe       = ctlHit & (wrData[7:6] == 2'b11) & wrData[1 + CHAN_ID];
    newMode    = (wrData[3:2] == 2'b11) ? {1'b0, wrData[2:1]} : wrData[3:1];
    dataWr     = wrEn & ~wrCtl;
    countDone  = dataWr & ((acc != ACC_BOTH) | wrHi);
    gateRise   = gate & ~gatePrev;
    hwMode     = (modeSel == MODE_ONESH) | (modeSel == MODE_HWSTB);
    periodic   = (modeSel == MODE_RATE) | (modeSel == MODE_SQR);
    countOn    = hwMode | gate;
    doLoad     = cntTick & (armed | (loadPend & gate));
    termReload = cntTick & running & periodic & gate & (ceVal == CNT_W'(1)) & ~doLoad;
    ctl.load   = doLoad | termReload;
    ctl.dec    = cntTick & running & ~ctl.load & countOn;
    srcVal     = latchValid ? latchVal : ceVal;
    byteHi     = (acc == ACC_HI) | ((acc == ACC_BOTH) & rdHi);
    rdData     = statusValid ? statusVal
               : (byteHi ? srcVal[CNT_W-1 -: BYTE_W] : srcVal[BYTE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSel <= MODE_TERM; acc <= ACC_LO; bcdSel <= 1'b0; reloadVal <= '0;
      outQ <= 1'b0; nullCnt <= 1'b0; loadPend <= 1'b0; armed <= 1'b0;
      running <= 1'b0; pulseArm <= 1'b0; crValid <= 1'b0; wrHi <= 1'b0;
      rdHi <= 1'b0; latchValid <= 1'b0; statusValid <= 1'b0; gatePrev <= 1'b0;
      latchVal <= '0; statusVal <= '0;
    end else begin
      gatePrev <= gate;
      if (isCtlWord) begin
        modeSel <= newMode; acc <= wrData[5:4]; bcdSel <= wrData[0];
        outQ <= (newMode != MODE_TERM); nullCnt <= 1'b1;
        loadPend <= 1'b0; armed <= 1'b0; running <= 1'b0; pulseArm <= 1'b0;
        crValid <= 1'b0; wrHi <= 1'b0; rdHi <= 1'b0;
        latchValid <= 1'b0; statusValid <= 1'b0;
      end else begin
        // reading first, so that a snapshot taken in the same cycle wins
        if (rdEn) begin
          if (statusValid) statusValid <= 1'b0;
          else if ((acc == ACC_BOTH) && !rdHi) rdHi <= 1'b1;
          else begin rdHi <= 1'b0; latchValid <= 1'b0; end
        end
        if ((isLatchCmd | (rbMe & wrData[5])) && !latchValid) begin
          latchVal <= ceVal; latchValid <= 1'b1;
        end
        if (rbMe && wrData[4] && !statusValid) begin
          statusVal <= BYTE_W'({outQ, nullCnt, acc, modeSel, bcdSel});
          statusValid <= 1'b1;
        end
        if (dataWr) begin
          case (acc)
            ACC_LO:  reloadVal <= {{BYTE_W{1'b0}}, wrData};
            ACC_HI:  reloadVal <= {wrData, {BYTE_W{1'b0}}};
            default: begin
              if (!wrHi) reloadVal[BYTE_W-1:0] <= wrData;
              else       reloadVal[CNT_W-1 -: BYTE_W] <= wrData;
              wrHi <= ~wrHi;
            end
          endcase
        end
        if (countDone) begin
          nullCnt <= 1'b1; crValid <= 1'b1;
          case (modeSel)
            MODE_TERM:           begin outQ <= 1'b0; loadPend <= 1'b1; running <= 1'b0; end
            MODE_SWSTB:          begin loadPend <= 1'b1; running <= 1'b0; end
            MODE_RATE, MODE_SQR: if (!running) loadPend <= 1'b1;
            default: ;
          endcase
        end
        if (gateRise && crValid && hwMode) armed <= 1'b1;
        if (gateRise && crValid && periodic) loadPend <= 1'b1;
        if (periodic && !gate) outQ <= 1'b1;
        if (ctl.load) begin
          running <= 1'b1; nullCnt <= 1'b0; loadPend <= 1'b0; armed <= 1'b0;
          pulseArm <= doLoad;
          if (modeSel == MODE_ONESH)     outQ <= 1'b0;
          else if (modeSel != MODE_TERM) outQ <= 1'b1;
        end else if (ctl.dec) begin
          case (modeSel)
            MODE_TERM, MODE_ONESH: if (ceDec == '0) outQ <= 1'b1;
            MODE_RATE:             outQ <= (ceDec != CNT_W'(1));
            MODE_SQR:              outQ <= (ceDec > halfVal);
            default: begin
              if ((ceDec == '0) && pulseArm) begin outQ <= 1'b0; pulseArm <= 1'b0; end
              else outQ <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign outPin = outQ;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic              gate,
  input  logic              wrEn,
  input  logic              wrCtl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output logic [BYTE_W-1:0] rdData,
  output logic              outPin
);
  localparam int CNT_W = 2 * BYTE_W;

  ceCtlT            ctl;
  logic [CNT_W-1:0] ceVal, ceDec, halfVal, reloadVal;
  logic [2:0]       modeSel;
  logic             bcdSel;

  pit_chan_ctrl #(.CHAN_ID(CHAN_ID), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .gate(gate),
    .wrEn(wrEn), .wrCtl(wrCtl), .wrData(wrData), .rdEn(rdEn),
    .ceVal(ceVal), .ceDec(ceDec), .halfVal(halfVal),
    .ctl(ctl), .reloadVal(reloadVal), .modeSel(modeSel), .bcdSel(bcdSel),
    .outPin(outPin), .rdData(rdData)
  );

  pit_count_path #(.CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reloadVal(reloadVal), .bcdSel(bcdSel),
    .ceVal(ceVal), .ceDec(ceDec), .halfVal(halfVal)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cntTick,
  input logic              gate,
  input logic              wrEn,
  input logic              wrCtl,
  input logic [BYTE_W-1:0] wrData,
  input logic              outPin,
  input logic [2:0]        modeSel
);

  // R1: a control word for this channel sets the output start level
  p_ctl_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCtl && wrData[7:6] == 2'(CHAN_ID) && wrData[5:4] != 2'b00)
      |=> (outPin == (|$past(wrData[3:1]))));

  // R3: once high in mode 0 the output holds until the next write
  p_term_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && outPin && !wrEn) |=> outPin);

  // R4: in mode 1 the output moves only on a count tick or a write
  p_onesh_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd1 && !cntTick && !wrEn) |=> (outPin == $past(outPin)));

  // R5: the rate pulse lasts a single tick
  p_rate_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd2 && !outPin && cntTick && gate && !wrEn) |=> outPin);

  // R5, R6: a low gate forces the periodic modes high
  p_gate_force_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == 3'd2 || modeSel == 3'd3) && !gate && !wrEn) |=> outPin);

  // R7, R8: a strobe pulse lasts a single tick
  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    (((modeSel == 3'd4 && gate) || modeSel == 3'd5) && !outPin && cntTick && !wrEn)
      |=> outPin);

endmodule

bind pit_channel pit_channel_chk #(.CHAN_ID(CHAN_ID), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .gate(gate), .wrEn(wrEn),
  .wrCtl(wrCtl), .wrData(wrData), .outPin(outPin), .modeSel(modeSel)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntTick = 1'b0;
  logic       gate = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrCtl = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       outPin;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  pit_channel #(.CHAN_ID(0), .BYTE_W(8)) i_pit_channel (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .gate(gate), .wrEn(wrEn),
    .wrCtl(wrCtl), .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .outPin(outPin)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtlWord(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrCtl = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrCtl = 1'b0;
  endtask

  task automatic wrByte(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrCtl = 1'b0; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdByte(output logic [7:0] v);
    @(negedge clk); v = rdData; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntTick = 1'b1;
      @(negedge clk); cntTick = 1'b0;
    end
  endtask

  task automatic setGate(input logic v);
    @(negedge clk); gate = v;
    @(negedge clk);
  endtask

  // read back the status byte only
  task automatic chkStatus(input string req, input int exp);
    logic [7:0] v;
    wrCtlWord(8'hD2);
    rdByte(v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset outPin", outPin, 0);
    chk("R1 reset rdData", rdData, 0);

    // R1: start levels and status layout
    wrCtlWord(8'h14);
    chk("R1 mode2 start high", outPin, 1);
    wrCtlWord(8'h31);
    chk("R1 mode0 start low", outPin, 0);
    chkStatus("R11 status after control", 8'h71);
    // R13: a control word for channel 1 is ignored
    wrCtlWord(8'h54);
    chk("R13 other channel out", outPin, 0);
    chkStatus("R13 other channel status", 8'h71);

    // R3, R12: mode 0 terminal count
    wrCtlWord(8'h30);
    wrByte(8'h05); wrByte(8'h00);
    chk("R3 low after write", outPin, 0);
    chkStatus("R12 null count set", 8'h70);
    ticks(1);
    chkStatus("R12 null count cleared", 8'h30);
    for (int k = 2; k <= 7; k++) begin
      ticks(1);
      chk($sformatf("R3 mode0 tick %0d", k), outPin, (k >= 6));
    end
    // R3: gate low holds the count
    wrCtlWord(8'h30);
    wrByte(8'h03); wrByte(8'h00);
    ticks(1);
    setGate(1'b0);
    ticks(5);
    chk("R3 gate low holds", outPin, 0);
    setGate(1'b1);
    for (int k = 1; k <= 3; k++) begin
      ticks(1);
      chk($sformatf("R3 after gate tick %0d", k), outPin, (k >= 3));
    end

    // R4: mode 1 one-shot with retrigger
    wrCtlWord(8'h32);
    wrByte(8'h03); wrByte(8'h00);
    ticks(2);
    chk("R4 no trigger stays high", outPin, 1);
    setGate(1'b0); setGate(1'b1);
    ticks(2);
    chk("R4 low after trigger", outPin, 0);
    setGate(1'b0); setGate(1'b1);
    for (int k = 1; k <= 4; k++) begin
      ticks(1);
      chk($sformatf("R4 retrigger tick %0d", k), outPin, (k >= 4));
    end

    // R5, R2: rate generator with low-byte-only access
    for (int n = 2; n <= 6; n++) begin
      wrCtlWord(8'h14);
      wrByte(8'(n));
      for (int k = 1; k <= 3 * n; k++) begin
        ticks(1);
        chk($sformatf("R5 rate n=%0d tick %0d", n, k), outPin, ((k % n) != 0));
      end
      setGate(1'b0);
      chk($sformatf("R5 gate low n=%0d", n), outPin, 1);
      ticks(2);
      chk($sformatf("R5 gate low hold n=%0d", n), outPin, 1);
      setGate(1'b1);
      for (int k = 1; k <= n; k++) begin
        ticks(1);
        chk($sformatf("R5 restart n=%0d tick %0d", n, k), outPin, ((k % n) != 0));
      end
    end

    // R6: square wave, binary counts
    for (int n = 2; n <= 7; n++) begin
      wrCtlWord(8'h16);
      wrByte(8'(n));
      for (int k = 1; k <= 2 * n; k++) begin
        ticks(1);
        chk($sformatf("R6 square n=%0d tick %0d", n, k), outPin,
            ((n - ((k - 1) % n)) > (n / 2)));
      end
    end

    // R7: software strobe
    wrCtlWord(8'h38);
    wrByte(8'h04); wrByte(8'h00);
    for (int k = 1; k <= 8; k++) begin
      ticks(1);
      chk($sformatf("R7 strobe tick %0d", k), outPin, (k != 5));
    end

    // R8: hardware strobe with retrigger
    wrCtlWord(8'h3A);
    wrByte(8'h03); wrByte(8'h00);
    ticks(3);
    chk("R8 waits for gate", outPin, 1);
    setGate(1'b0); setGate(1'b1);
    for (int k = 1; k <= 6; k++) begin
      ticks(1);
      chk($sformatf("R8 strobe tick %0d", k), outPin, (k != 4));
    end
    setGate(1'b0); setGate(1'b1);
    ticks(2);
    setGate(1'b0); setGate(1'b1);
    for (int k = 1; k <= 5; k++) begin
      ticks(1);
      chk($sformatf("R8 retrigger tick %0d", k), outPin, (k != 4));
    end

    // R2: high-byte-only access
    wrCtlWord(8'h24);
    wrByte(8'h01);
    ticks(1);
    wrCtlWord(8'h00);
    rdByte(b0);
    chk("R2 high byte latched", b0, 8'h01);
    ticks(1);
    rdByte(b0);
    chk("R2 high byte live", b0, 8'h00);

    // R10: latch holds while counting continues
    wrCtlWord(8'h34);
    wrByte(8'hE8); wrByte(8'h03);
    ticks(6);
    wrCtlWord(8'h00);
    ticks(3);
    wrCtlWord(8'h00);
    rdByte(b0); rdByte(b1);
    chk("R10 latched low", b0, 8'hE3);
    chk("R10 latched high", b1, 8'h03);
    rdByte(b0); rdByte(b1);
    chk("R10 live low after release", b0, 8'hE0);
    chk("R10 live high after release", b1, 8'h03);

    // R9: decimal countdown and wrap
    wrCtlWord(8'h31);
    wrByte(8'h10); wrByte(8'h00);
    ticks(2);
    rdByte(b0); rdByte(b1);
    chk("R9 decimal borrow low", b0, 8'h09);
    chk("R9 decimal borrow high", b1, 8'h00);
    ticks(8);
    chk("R9 decimal before zero", outPin, 0);
    ticks(1);
    chk("R9 decimal at zero", outPin, 1);
    ticks(1);
    rdByte(b0); rdByte(b1);
    chk("R9 decimal wrap low", b0, 8'h99);
    chk("R9 decimal wrap high", b1, 8'h99);
    wrCtlWord(8'h30);
    wrByte(8'h02); wrByte(8'h00);
    ticks(4);
    rdByte(b0); rdByte(b1);
    chk("R9 binary wrap low", b0, 8'hFF);
    chk("R9 binary wrap high", b1, 8'hFF);

    // R6, R9: decimal square wave with an odd count of eleven
    wrCtlWord(8'h37);
    wrByte(8'h11); wrByte(8'h00);
    for (int k = 1; k <= 22; k++) begin
      ticks(1);
      chk($sformatf("R6 decimal square tick %0d", k), outPin,
          ((11 - ((k - 1) % 11)) > 5));
    end

    // R11: read-back of status then count
    wrCtlWord(8'h34);
    wrByte(8'h10); wrByte(8'h00);
    ticks(3);
    wrCtlWord(8'hF2);
    ticks(2);
    rdByte(b0);
    chk("R11 status first", b0, 8'hB4);
    rdByte(b0); rdByte(b1);
    chk("R11 count low", b0, 8'h0E);
    chk("R11 count high", b1, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule